// File: doc/BRIEF.md
# Capture FIFO Overrun Recovery Controller

This block sits between one data capture channel and the FIFO that a DMA engine drains. Incoming words are written into a 16-entry by 32-bit FIFO while the channel is live. A DMA request is raised once enough words have collected. If a word arrives while the FIFO is already full, that word is lost. A sticky overrun flag is then set, and an interrupt line follows the flag when software has enabled it.

Recovery is driven by a block control bit. Setting it empties the FIFO in a single clock and gags the channel: arriving words are dropped and DMA requests are held off. The per-frame word counter keeps counting all the while. Clearing the bit does not reopen the channel at once. The block first waits for the capture enable input to sit low for at least one clock, then for its next rising edge. The word on that edge is the first one accepted. DMA requests therefore stay off for the remainder of the frame in which the bit was cleared.

Register accesses are modelled as single-cycle write strobes with a data bit each. The DMA engine is modelled as a pop strobe with a show-ahead data output.

Top module: `cap_ovr_recover`

## Requirements
- R1: When the channel is live, a word on `din` with `din_vld` and `cap_en` both high is stored, and words leave through `dma_dout`/`dma_pop` first-in first-out. `fifo_level` gives the occupancy, and a pop on an empty FIFO is ignored.
- R2: `dma_req` is high exactly when `chan_live` is high and `fifo_level` is at least DMA_THRESH (default 4).
- R3: A write attempt while `fifo_level` equals the depth (16) drops the word, leaves the FIFO unchanged and sets `ovr_sts`. The flag stays set until it is cleared.
- R4: `irq` is high exactly when `ovr_sts` is set and the interrupt enable bit is 1. The enable bit is loaded from `wr_ien_val` on a `wr_ien` strobe and resets to 0.
- R5: A `wr_stat` strobe with `wr_stat_ovr`=1 clears `ovr_sts`, and with `wr_stat_ovr`=0 it leaves the flag alone. A new overrun in the same cycle as a clear wins.
- R6: A `wr_ctl` strobe with `wr_ctl_block`=1 makes `fifo_level` 0 on the next cycle. This flush takes priority over a push or pop in the same cycle.
- R7: While `ctl_block` is 1, or while a resume is pending, `chan_live` is 0, incoming words are discarded, and `dma_req` stays 0. No overrun is flagged in that time.
- R8: `frame_cnt` advances by one for every word seen with `cap_en` high, whether or not the channel is blocked. On the cycle in which `cap_en` rises, it restarts at 1 if a word is present and at 0 otherwise.
- R9: After a `wr_ctl` strobe with `wr_ctl_block`=0 clears the block, the channel stays gated until `cap_en` has been low for at least one clock and then rises. The word on that rising cycle is the first one stored, and `chan_live` reads 1 from the following cycle.
- R10: A `wr_ctl` strobe with `wr_ctl_block`=0 while the channel is already live has no effect. `ctl_block` reads 1 only from the cycle after a block write until the cycle after a clear write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture enable; a low period followed by a rise marks a frame start |
| din_vld | input | 1 | Incoming data word valid |
| din | input | 32 | Incoming data word |
| dma_pop | input | 1 | DMA engine takes the head word |
| dma_dout | output | 32 | Head word of the FIFO (show-ahead) |
| dma_req | output | 1 | DMA request event |
| fifo_level | output | 5 | FIFO occupancy |
| frame_cnt | output | 16 | Words seen in the current frame |
| wr_ctl | input | 1 | Control register write strobe |
| wr_ctl_block | input | 1 | Block bit value written with `wr_ctl` |
| wr_ien | input | 1 | Interrupt enable write strobe |
| wr_ien_val | input | 1 | Overrun interrupt enable value |
| wr_stat | input | 1 | Status register write strobe |
| wr_stat_ovr | input | 1 | Write-one-to-clear bit for the overrun flag |
| ovr_sts | output | 1 | Sticky overrun flag |
| irq | output | 1 | Overrun interrupt |
| ctl_block | output | 1 | Block bit readback |
| chan_live | output | 1 | Channel is storing data and may request DMA |

## Verification
The bench fills the FIFO to its limit and writes once more, both with the interrupt enable off and with it on. A design that counted the overrun word into the FIFO, or raised the interrupt without the enable, is caught by the level and `irq` checks. It sets the block bit in the same cycle as a push and a pop, which catches a flush that loses to either one. It also keeps words arriving while blocked, so a counter that freezes with the channel shows a wrong `frame_cnt`. After the block is cleared, it continues the same frame before dropping `cap_en`. A design that resumed on the clear write or on the next word would store data too early, and the check of the first stored word after the frame edge exposes it.

// File: rtl/cap_ovr_pkg.sv
package cap_ovr_pkg;

    parameter int unsigned FIFO_DEPTH = 16;
    parameter int unsigned DATA_W     = 32;
    parameter int unsigned CNT_W      = 16;
    parameter int unsigned DMA_THRESH = 4;

    typedef enum logic [1:0] {
        CH_RUN       = 2'd0,
        CH_HALT      = 2'd1,
        CH_WAIT_LOW  = 2'd2,
        CH_WAIT_RISE = 2'd3
    } chan_state_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic flush;
    } fifo_cmd_t;

    // Recovery sequencing: block write wins, then the resume walk.
    function automatic chan_state_e chan_next(
        input chan_state_e cur,
        input logic        set_block,
        input logic        clr_block,
        input logic        en
    );
        chan_state_e nxt;
        nxt = cur;
        if (set_block) begin
            nxt = CH_HALT;
        end else begin
            unique case (cur)
                CH_RUN:       nxt = CH_RUN;
                CH_HALT:      nxt = clr_block ? CH_WAIT_LOW : CH_HALT;
                CH_WAIT_LOW:  nxt = en ? CH_WAIT_LOW : CH_WAIT_RISE;
                CH_WAIT_RISE: nxt = en ? CH_RUN : CH_WAIT_RISE;
                default:      nxt = CH_HALT;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/cap_ovr_fifo.sv
module cap_ovr_fifo
    import cap_ovr_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    parameter int unsigned DW    = DATA_W,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  fifo_cmd_t     cmd,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level,
    output logic          full
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [LW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == LW'(DEPTH));
    assign do_push = cmd.push && !full && !cmd.flush;
    assign do_pop  = cmd.pop && (cnt_q != '0) && !cmd.flush;
    assign rdata   = mem[rp_q];
    assign level   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp_q] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + AW'(1);
            if (do_pop)  rp_q <= rp_q + AW'(1);
            cnt_q <= cnt_q + LW'(do_push) - LW'(do_pop);
        end
    end

endmodule

// File: rtl/cap_ovr_frame.sv
module cap_ovr_frame
    import cap_ovr_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_en,
    input  logic          din_vld,
    output logic          word_in,
    output logic [CW-1:0] frame_cnt
);

    logic en_q;
    logic frame_start;

    assign word_in     = cap_en && din_vld;
    assign frame_start = cap_en && !en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            frame_cnt <= '0;
        end else begin
            en_q <= cap_en;
            if (frame_start) begin
                frame_cnt <= CW'(word_in);
            end else if (word_in) begin
                frame_cnt <= frame_cnt + CW'(1);
            end
        end
    end

endmodule

// File: rtl/cap_ovr_ctrl.sv
module cap_ovr_ctrl
    import cap_ovr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_en,
    input  logic        word_in,
    input  logic        fifo_full,
    input  logic        wr_ctl,
    input  logic        wr_ctl_block,
    input  logic        wr_ien,
    input  logic        wr_ien_val,
    input  logic        wr_stat,
    input  logic        wr_stat_ovr,
    output chan_state_e state,
    output logic        accept,
    output logic        flush,
    output logic        ovr_sts,
    output logic        irq
);

    logic ien_q;
    logic overrun;
    logic open_now;

    assign flush    = wr_ctl && wr_ctl_block;
    assign open_now = (state == CH_RUN) || (state == CH_WAIT_RISE && cap_en);
    assign accept   = word_in && open_now && !flush;
    assign overrun  = accept && fifo_full;
    assign irq      = ovr_sts && ien_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= CH_RUN;
            ovr_sts <= 1'b0;
            ien_q   <= 1'b0;
        end else begin
            state <= chan_next(state, flush, wr_ctl && !wr_ctl_block, cap_en);
            if (overrun) begin
                ovr_sts <= 1'b1;
            end else if (wr_stat && wr_stat_ovr) begin
                ovr_sts <= 1'b0;
            end
            if (wr_ien) begin
                ien_q <= wr_ien_val;
            end
        end
    end

endmodule

// File: rtl/cap_ovr_recover.sv
module cap_ovr_recover
    import cap_ovr_pkg::*;
#(
    parameter int unsigned DEPTH  = FIFO_DEPTH,
    parameter int unsigned DW     = DATA_W,
    parameter int unsigned CW     = CNT_W,
    parameter int unsigned THRESH = DMA_THRESH,
    localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_en,
    input  logic          din_vld,
    input  logic [DW-1:0] din,
    input  logic          dma_pop,
    output logic [DW-1:0] dma_dout,
    output logic          dma_req,
    output logic [LW-1:0] fifo_level,
    output logic [CW-1:0] frame_cnt,
    input  logic          wr_ctl,
    input  logic          wr_ctl_block,
    input  logic          wr_ien,
    input  logic          wr_ien_val,
    input  logic          wr_stat,
    input  logic          wr_stat_ovr,
    output logic          ovr_sts,
    output logic          irq,
    output logic          ctl_block,
    output logic          chan_live
);

    chan_state_e state;
    fifo_cmd_t   cmd;
    logic        word_in, accept, flush, full;

    cap_ovr_frame #(.CW(CW)) frame_i (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .din_vld   (din_vld),
        .word_in   (word_in),
        .frame_cnt (frame_cnt)
    );

    cap_ovr_ctrl ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .cap_en       (cap_en),
        .word_in      (word_in),
        .fifo_full    (full),
        .wr_ctl       (wr_ctl),
        .wr_ctl_block (wr_ctl_block),
        .wr_ien       (wr_ien),
        .wr_ien_val   (wr_ien_val),
        .wr_stat      (wr_stat),
        .wr_stat_ovr  (wr_stat_ovr),
        .state        (state),
        .accept       (accept),
        .flush        (flush),
        .ovr_sts      (ovr_sts),
        .irq          (irq)
    );

    assign cmd.push  = accept;
    assign cmd.pop   = dma_pop;
    assign cmd.flush = flush;

    cap_ovr_fifo #(.DEPTH(DEPTH), .DW(DW)) fifo_i (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .wdata (din),
        .rdata (dma_dout),
        .level (fifo_level),
        .full  (full)
    );

    assign chan_live = (state == CH_RUN);
    assign ctl_block = (state == CH_HALT);
    assign dma_req   = chan_live && (fifo_level >= LW'(THRESH));

endmodule

// File: rtl/cap_ovr_checker.sv
module cap_ovr_checker #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          cap_en,
    input logic          din_vld,
    input logic          dma_req,
    input logic [LW-1:0] fifo_level,
    input logic          wr_ctl,
    input logic          wr_ctl_block,
    input logic          wr_stat,
    input logic          wr_stat_ovr,
    input logic          ovr_sts,
    input logic          irq,
    input logic          ctl_block,
    input logic          chan_live
);

    p_level_bound_r1: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LW'(DEPTH));

    p_overrun_set_r3: assert property (@(posedge clk) disable iff (rst)
        (din_vld && cap_en && chan_live && fifo_level == LW'(DEPTH)
         && !(wr_ctl && wr_ctl_block)) |=> ovr_sts);

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (ovr_sts && !(wr_stat && wr_stat_ovr)) |=> ovr_sts);

    p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> ovr_sts);

    p_flush_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && wr_ctl_block) |=> (fifo_level == '0));

    p_gated_no_req_r7: assert property (@(posedge clk) disable iff (rst)
        !chan_live |-> !dma_req);

    p_block_not_live_r10: assert property (@(posedge clk) disable iff (rst)
        ctl_block |-> !chan_live);

endmodule

bind cap_ovr_recover cap_ovr_checker #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/cap_ovr_recover_tb_top.sv
`timescale 1ns/100ps
module cap_ovr_recover_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cap_en, din_vld, dma_pop;
    logic [31:0] din, dma_dout;
    logic        dma_req;
    logic [4:0]  fifo_level;
    logic [15:0] frame_cnt;
    logic        wr_ctl, wr_ctl_block, wr_ien, wr_ien_val, wr_stat, wr_stat_ovr;
    logic        ovr_sts, irq, ctl_block, chan_live;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;

    always #2.5 clk = ~clk;

    cap_ovr_recover dut_i (
        .clk(clk), .rst(rst), .cap_en(cap_en), .din_vld(din_vld), .din(din),
        .dma_pop(dma_pop), .dma_dout(dma_dout), .dma_req(dma_req),
        .fifo_level(fifo_level), .frame_cnt(frame_cnt),
        .wr_ctl(wr_ctl), .wr_ctl_block(wr_ctl_block),
        .wr_ien(wr_ien), .wr_ien_val(wr_ien_val),
        .wr_stat(wr_stat), .wr_stat_ovr(wr_stat_ovr),
        .ovr_sts(ovr_sts), .irq(irq), .ctl_block(ctl_block), .chan_live(chan_live)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        din_vld = 0; dma_pop = 0; wr_ctl = 0; wr_ctl_block = 0;
        wr_ien = 0; wr_ien_val = 0; wr_stat = 0; wr_stat_ovr = 0;
    endtask

    task automatic t_reset();
        rst = 1; cap_en = 0; din = '0; idle();
        repeat (3) tick();
        rst = 0;
        tick();
        chk("R1 reset level", fifo_level, 0);
        chk("R3 reset ovr", ovr_sts, 0);
        chk("R4 reset irq", irq, 0);
        chk("R2 reset req", dma_req, 0);
        chk("R8 reset count", frame_cnt, 0);
        chk("R10 reset live", chan_live, 1);
    endtask

    task automatic t_fill_drain();
        cap_en = 0; tick();
        cap_en = 1; din_vld = 1;
        for (int i = 0; i < 5; i++) begin
            din = 32'd100 + 32'(i);
            tick();
            exp_cnt = i + 1;
            chk("R1 level fill", fifo_level, 5'(i + 1));
            chk("R2 req fill", dma_req, (i + 1) >= 4);
        end
        chk("R8 count restart", frame_cnt, 16'(exp_cnt));
        din_vld = 0;
        dma_pop = 1;
        for (int i = 0; i < 5; i++) begin
            chk("R1 order", dma_dout, 32'd100 + 32'(i));
            tick();
            chk("R2 req drain", dma_req, (4 - i) >= 4);
        end
        chk("R1 drained", fifo_level, 0);
        tick();
        chk("R1 pop empty ignored", fifo_level, 0);
        dma_pop = 0;
    endtask

    task automatic t_overrun();
        din_vld = 1;
        for (int i = 0; i < 16; i++) begin
            din = 32'h200 + 32'(i);
            tick();
            exp_cnt++;
        end
        chk("R1 full", fifo_level, 16);
        chk("R3 no ovr yet", ovr_sts, 0);
        din = 32'hDEAD;
        tick(); exp_cnt++;
        chk("R3 ovr set", ovr_sts, 1);
        chk("R3 level kept", fifo_level, 16);
        chk("R4 irq masked", irq, 0);
        chk("R8 counts overrun word", frame_cnt, 16'(exp_cnt));
        din_vld = 0;
        wr_stat = 1; wr_stat_ovr = 0; tick();
        chk("R5 write 0 keeps", ovr_sts, 1);
        wr_stat = 0;
        wr_ien = 1; wr_ien_val = 1; tick();
        wr_ien = 0;
        chk("R4 irq enabled", irq, 1);
        wr_stat = 1; wr_stat_ovr = 1; tick();
        chk("R5 w1c clears", ovr_sts, 0);
        chk("R4 irq drops", irq, 0);
        din_vld = 1; din = 32'hBEEF; tick(); exp_cnt++;
        chk("R5 set beats clear", ovr_sts, 1);
        idle(); wr_stat = 1; wr_stat_ovr = 1; tick();
        wr_stat = 0; wr_stat_ovr = 0;
        chk("R3 head kept", dma_dout, 32'h200);
    endtask

    task automatic t_block();
        wr_ctl = 1; wr_ctl_block = 0; tick();
        chk("R10 clear while live", chan_live, 1);
        chk("R10 level untouched", fifo_level, 16);
        wr_ctl_block = 1; din_vld = 1; din = 32'h77; dma_pop = 1;
        tick(); exp_cnt++;
        idle();
        chk("R6 flush wins", fifo_level, 0);
        chk("R10 block readback", ctl_block, 1);
        chk("R7 not live", chan_live, 0);
        din_vld = 1;
        for (int i = 0; i < 6; i++) begin
            din = 32'h300 + 32'(i);
            tick(); exp_cnt++;
        end
        din_vld = 0;
        chk("R7 discarded", fifo_level, 0);
        chk("R7 req off", dma_req, 0);
        chk("R7 no overrun", ovr_sts, 0);
        chk("R8 counts blocked", frame_cnt, 16'(exp_cnt));
    endtask

    task automatic t_resume();
        wr_ctl = 1; wr_ctl_block = 0; din_vld = 1; din = 32'h400;
        tick(); exp_cnt++;
        wr_ctl = 0;
        chk("R10 block cleared", ctl_block, 0);
        chk("R9 still gated", chan_live, 0);
        for (int i = 0; i < 3; i++) begin
            din = 32'h401 + 32'(i);
            tick(); exp_cnt++;
        end
        chk("R9 rest of frame dropped", fifo_level, 0);
        chk("R9 req off", dma_req, 0);
        chk("R8 count continues", frame_cnt, 16'(exp_cnt));
        cap_en = 0; din_vld = 0; tick();
        chk("R9 low seen not live", chan_live, 0);
        cap_en = 1; din_vld = 1; din = 32'h500; tick();
        chk("R9 edge word stored", fifo_level, 1);
        chk("R9 live after edge", chan_live, 1);
        chk("R8 count restart", frame_cnt, 1);
        for (int i = 1; i < 5; i++) begin
            din = 32'h500 + 32'(i);
            tick();
        end
        din_vld = 0;
        chk("R9 level", fifo_level, 5);
        chk("R2 req resumed", dma_req, 1);
        chk("R9 first word", dma_dout, 32'h500);
    endtask

    initial begin
        t_reset();
        t_fill_drain();
        t_overrun();
        t_block();
        t_resume();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule